// File: doc/BRIEF.md
# Pipelined Eight-Bit ALU with Status Flags

This block is an eight-bit arithmetic unit with a fixed three-register pipeline. Operand A comes in on a full byte. A second input byte carries a five-bit operand B in its upper bits and a three-bit operation code in its lower bits. Both operands are zero-extended to a 32-bit internal width. The unit then computes a sum, difference, product, quotient, left shift or right shift.

The low byte of the internal result appears on the result port three clock edges after the inputs are sampled. Four status flags for that same result appear alongside it on the low half of a bidirectional output byte. A new operation can enter on every clock edge. Results wrap modulo 256. Division by zero and the two unused operation codes give a zero result.

The bidirectional output-enable byte is fixed, so that only the four flag bits drive.

Top module: `alu8_pipe_top`

## Requirements
- R1: Operand B is taken from `bidir_i[7:3]` and the operation code from `bidir_i[2:0]`. Operand A is `op_a_i`. Both operands are zero-extended before use.
- R2: Code 000 adds. The result is the low byte of A+B. Carry (flag bit 1) is set when A+B exceeds 255. Overflow (flag bit 0) is set on signed eight-bit overflow, which means the operands share a sign bit and the result's sign bit differs.
- R3: Code 001 subtracts. The result is (A−B) mod 256. Carry is set as a borrow when A < B. Overflow stays 0.
- R4: Code 010 multiplies. The result is the low byte of A×B. Carry and overflow stay 0.
- R5: Code 011 divides. The result is the unsigned quotient A/B, truncated. When B is 0 the result is 0. Carry and overflow stay 0.
- R6: Code 100 gives the low byte of A shifted left by B places. Code 101 gives A shifted right by B places. Any distance of 8 or more yields 0. Carry and overflow stay 0.
- R7: Codes 110 and 111 yield a zero result, with carry and overflow at 0.
- R8: The zero flag (bit 3) is set exactly when the result byte is 0. The negative flag (bit 2) equals bit 7 of the result byte.
- R9: `bidir_o[3:0]` carries {zero, negative, carry, overflow}. `bidir_o[7:4]` is 0. `bidir_oe_o` is always 8'h0F.
- R10: Inputs sampled at a clock edge appear on the outputs right after the third edge counting from that one. A new operation is accepted on every edge, and each flag set matches the result shown with it.
- R11: An active-low `rst_n` asynchronously clears the result and all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 8 | Operand A |
| bidir_i | input | 8 | Operand B in bits 7..3, operation code in bits 2..0 |
| res_o | output | 8 | Result byte, three edges after its inputs |
| bidir_o | output | 8 | Flags {zero, negative, carry, overflow} in bits 3..0; bits 7..4 are zero |
| bidir_oe_o | output | 8 | Output-enable byte, constant 8'h0F |

## Verification
A wrong value in any pipeline register reaches the ports no later than the third edge after it was loaded. It then lasts for exactly one cycle, so every vector streamed back to back is checked on its own. Flags that drift out of step with their result show up at once as a zero or negative flag that disagrees with the visible result byte. A stage that has been skipped or doubled moves every result one cycle early or late. That is caught both by the streamed table and by a lone operation placed between zero-result operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu8_unpack.sv
module alu8_unpack
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int B_W    = 5,
    parameter int INT_W  = 32
) (
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] bidir_i,
    output logic [INT_W-1:0]  a_o,
    output logic [INT_W-1:0]  b_o,
    output alu_op_e           op_o
);
    localparam int OPC_W = DATA_W - B_W;

    // R1: operand B sits above the operation code in the same byte
    assign a_o  = INT_W'(op_a_i);
    assign b_o  = INT_W'(bidir_i[DATA_W-1:OPC_W]);
    assign op_o = alu_op_e'(bidir_i[OPC_W-1:0]);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int INT_W  = 32
) (
    input  logic [INT_W-1:0]  a_i,
    input  logic [INT_W-1:0]  b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output alu_flags_t        flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [INT_W-1:0] wide;
    logic             carry;
    logic             ovf;
    logic             unused_hi;

    always_comb begin
        wide  = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                wide  = a_i + b_i;
                carry = wide[DATA_W];
                ovf   = (a_i[MSB] == b_i[MSB]) && (wide[MSB] != a_i[MSB]);
            end
            OP_SUB: begin
                wide  = a_i - b_i;
                carry = (a_i < b_i);
            end
            OP_MUL: wide = a_i * b_i;
            OP_DIV: wide = (b_i == '0) ? '0 : (a_i / b_i);
            OP_SHL: wide = a_i << b_i;
            OP_SHR: wide = a_i >> b_i;
            default: wide = '0;
        endcase
    end

    assign unused_hi = ^wide[INT_W-1:DATA_W+1];

    assign res_o         = wide[DATA_W-1:0];
    assign flags_o.zero  = (wide[DATA_W-1:0] == '0);
    assign flags_o.neg   = wide[MSB];
    assign flags_o.carry = carry;
    assign flags_o.ovf   = ovf;
endmodule

// File: rtl/alu8_pipe_regs.sv
module alu8_pipe_regs #(
    parameter int W      = 12,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/alu8_pipe_top.sv
module alu8_pipe_top
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int B_W    = 5,
    parameter int INT_W  = 32,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] bidir_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] bidir_o,
    output logic [DATA_W-1:0] bidir_oe_o
);
    localparam int WORD_W = DATA_W + FLAG_W;
    localparam logic [DATA_W-1:0] OE_MASK = DATA_W'((1 << FLAG_W) - 1);

    logic [INT_W-1:0]  a_w;
    logic [INT_W-1:0]  b_w;
    alu_op_e           op_w;
    logic [DATA_W-1:0] res_w;
    alu_flags_t        flags_w;
    logic [WORD_W-1:0] word_q;
    alu_flags_t        flags_q;

    alu8_unpack #(.DATA_W(DATA_W), .B_W(B_W), .INT_W(INT_W)) u_unpack (
        .op_a_i  (op_a_i),
        .bidir_i (bidir_i),
        .a_o     (a_w),
        .b_o     (b_w),
        .op_o    (op_w)
    );

    alu8_core #(.DATA_W(DATA_W), .INT_W(INT_W)) u_core (
        .a_i     (a_w),
        .b_i     (b_w),
        .op_i    (op_w),
        .res_o   (res_w),
        .flags_o (flags_w)
    );

    // result and its flags travel as one word so they stay aligned
    alu8_pipe_regs #(.W(WORD_W), .STAGES(STAGES)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({res_w, flags_w}),
        .q_o   (word_q)
    );

    assign res_o      = word_q[WORD_W-1:FLAG_W];
    assign flags_q    = alu_flags_t'(word_q[FLAG_W-1:0]);
    assign bidir_o    = {(DATA_W-FLAG_W)'(0), flags_q};
    assign bidir_oe_o = OE_MASK;
endmodule

// File: rtl/alu8_pipe_chk.sv
module alu8_pipe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] op_a_i,
    input logic [7:0] bidir_i,
    input logic [7:0] res_o,
    input logic [7:0] bidir_o,
    input logic [7:0] bidir_oe_o
);
    // edges seen since reset release; outputs are meaningful once this saturates
    logic [1:0] fill_q;
    logic       filled;
    logic       unused_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              fill_q <= 2'd0;
        else if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
    end
    assign filled    = (fill_q == 2'd3);
    assign unused_oe = ^bidir_oe_o;

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        filled |-> (bidir_o[3] == (res_o == 8'd0)));

    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        filled |-> (bidir_o[2] == res_o[7]));

    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i[2:0], 3) == 3'd0) |->
        (bidir_o[1] == (({1'b0, $past(op_a_i, 3)} + {4'd0, $past(bidir_i[7:3], 3)}) > 9'd255)));

    p_ovf_add_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i[2:0], 3) != 3'd0) |-> (bidir_o[0] == 1'b0));

    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i[2:0], 3) == 3'd1) |->
        (bidir_o[1] == ($past(op_a_i, 3) < {3'd0, $past(bidir_i[7:3], 3)})));

    p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i, 3) == 8'b00000_011) |-> (res_o == 8'd0));

    p_shift_far_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i[2:1], 3) == 2'b10 && $past(bidir_i[7:6], 3) != 2'b00)
        |-> (res_o == 8'd0));

    p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && $past(bidir_i[2:1], 3) == 2'b11) |->
        (res_o == 8'd0 && bidir_o[1:0] == 2'b00));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |-> (res_o == 8'd0 && bidir_o == 8'd0));
endmodule

bind alu8_pipe_top alu8_pipe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a_i     (op_a_i),
    .bidir_i    (bidir_i),
    .res_o      (res_o),
    .bidir_o    (bidir_o),
    .bidir_oe_o (bidir_oe_o)
);

// File: tb/alu8_pipe_top_test.sv
module alu8_pipe_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a_i = 8'd0;
    logic [7:0] bidir_i = 8'd0;
    logic [7:0] res_o;
    logic [7:0] bidir_o;
    logic [7:0] bidir_oe_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    alu8_pipe_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a_i     (op_a_i),
        .bidir_i    (bidir_i),
        .res_o      (res_o),
        .bidir_o    (bidir_o),
        .bidir_oe_o (bidir_oe_o)
    );

    // {a[27:20], b[19:15], op[14:12], result[11:4], flags {z,n,c,v}[3:0]}
    localparam int N = 22;
    localparam logic [27:0] VEC [N] = '{
        {8'd20,  5'd30, 3'd0, 8'd50,  4'b0000},  // R2 plain add
        {8'd250, 5'd10, 3'd0, 8'd4,   4'b0010},  // R2 carry out
        {8'd120, 5'd10, 3'd0, 8'd130, 4'b0101},  // R2 signed overflow
        {8'd0,   5'd0,  3'd0, 8'd0,   4'b1000},  // R2 R8 zero sum
        {8'd255, 5'd31, 3'd0, 8'd30,  4'b0010},  // R2 largest operands
        {8'd30,  5'd10, 3'd1, 8'd20,  4'b0000},  // R3
        {8'd5,   5'd9,  3'd1, 8'd252, 4'b0110},  // R3 borrow, wrap
        {8'd130, 5'd5,  3'd1, 8'd125, 4'b0000},  // R3 no overflow flag on sub
        {8'd7,   5'd7,  3'd1, 8'd0,   4'b1000},  // R3 equal operands
        {8'd6,   5'd7,  3'd2, 8'd42,  4'b0000},  // R4
        {8'd200, 5'd31, 3'd2, 8'd56,  4'b0000},  // R4 wraps, no carry
        {8'd128, 5'd2,  3'd2, 8'd0,   4'b1000},  // R4 wraps to zero
        {8'd100, 5'd7,  3'd3, 8'd14,  4'b0000},  // R5 truncation
        {8'd255, 5'd0,  3'd3, 8'd0,   4'b1000},  // R5 divide by zero
        {8'd3,   5'd5,  3'd3, 8'd0,   4'b1000},  // R5 quotient zero
        {8'd3,   5'd4,  3'd4, 8'd48,  4'b0000},  // R6 left
        {8'd1,   5'd7,  3'd4, 8'd128, 4'b0100},  // R6 left into sign bit
        {8'd255, 5'd8,  3'd4, 8'd0,   4'b1000},  // R6 left by 8
        {8'd200, 5'd3,  3'd5, 8'd25,  4'b0000},  // R6 right
        {8'd255, 5'd9,  3'd5, 8'd0,   4'b1000},  // R6 right by 9
        {8'd77,  5'd3,  3'd6, 8'd0,   4'b1000},  // R7 code 110
        {8'd255, 5'd31, 3'd7, 8'd0,   4'b1000}   // R7 code 111
    };

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:       return "R2";
            3'd1:       return "R3";
            3'd2:       return "R4";
            3'd3:       return "R5";
            3'd4, 3'd5: return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [4:0] b, input logic [2:0] op);
        op_a_i  = a;
        bidir_i = {b, op};   // R1 packing
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R11 reset state, R9 output enable
        repeat (3) @(negedge clk);
        check("R11 result in reset", 32'(res_o), 32'd0);
        check("R11 flags in reset", 32'(bidir_o), 32'd0);
        check("R9 output enable", 32'(bidir_oe_o), 32'h0F);
        rst_n = 1'b1;

        // streamed table: vector i shows three edges after it was driven (R10)
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                logic [27:0] v;
                v = VEC[i-3];
                check(op_tag(v[14:12]), 32'(res_o), 32'(v[11:4]));
                check("R8 R9 R10 flags", 32'(bidir_o), {28'd0, v[3:0]});
                check("R9 output enable", 32'(bidir_oe_o), 32'h0F);
            end
            if (i < N) drive(VEC[i][27:20], VEC[i][19:15], VEC[i][14:12]);
            else       drive(8'd0, 5'd0, 3'd7);
        end

        // R10 exact latency: a lone add between zero-result operations
        @(negedge clk);
        drive(8'd50, 5'd5, 3'd0);
        @(negedge clk);
        drive(8'd0, 5'd0, 3'd7);
        check("R10 not yet at one edge", 32'(res_o), 32'd0);
        @(negedge clk);
        check("R10 not yet at two edges", 32'(res_o), 32'd0);
        @(negedge clk);
        check("R10 at three edges", 32'(res_o), 32'd55);
        @(negedge clk);
        check("R10 held one cycle only", 32'(res_o), 32'd0);

        // R1 raw byte: 8'h1A is B=3, code 010 (multiply)
        op_a_i  = 8'd9;
        bidir_i = 8'h1A;
        @(negedge clk);
        drive(8'd0, 5'd0, 3'd7);
        repeat (2) @(negedge clk);
        check("R1 unpacking", 32'(res_o), 32'd27);

        // R11 asynchronous clear in mid-run
        drive(8'd100, 5'd20, 3'd0);
        repeat (3) @(negedge clk);
        check("R2 before reset", 32'(res_o), 32'd120);
        #1 rst_n = 1'b0;
        #0.5;
        check("R11 async result clear", 32'(res_o), 32'd0);
        check("R11 async flag clear", 32'(bidir_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end
endmodule